// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the low-order word address for a four-beat burst on a synchronous memory. When either address strobe is asserted and the chip-select pair qualifies the access, it captures a start address on the rising clock edge. The upper bits go to a holding register. The low bits become the start of a burst. After that, each cycle in which the advance input is asserted and no strobe is present moves the burst one beat forward.

A burst runs in one of two orders. Linear order counts up from the start word and wraps modulo four. Interleaved order XORs the start word with a beat count that runs 0, 1, 2, 3. The order is sampled from the mode pin when the start address is captured, and it holds for the rest of that burst. A strobe that finds the chip deselected drops the live flag, and advance has no effect until a new address is loaded. The memory array, the data paths and output enabling are handled elsewhere.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, `addr_hi` and `beat_addr` are zero and `burst_live` is low.
- R2: If `strobe_cpu_n` or `strobe_ctl_n` is low at a rising edge while `cs_n` is low and `cs` is high, then after that edge `addr_hi` equals the upper bits of `addr_in`, `beat_addr` equals `addr_in[1:0]`, and `burst_live` is high.
- R3: If a strobe is low at a rising edge while `cs_n` is high or `cs` is low, then after that edge `burst_live` is low, and `addr_hi` and `beat_addr` keep their values.
- R4: When the captured mode is linear (`mode_ilv` = 0 at load), each advance (`adv_n` low, no strobe, `burst_live` high) sets `beat_addr` to the previous value plus one, modulo 4.
- R5: When the captured mode is interleaved (`mode_ilv` = 1 at load), `beat_addr` equals the start word XOR the number of advances since load, modulo 4. For a start of 1 this gives 1, 0, 3, 2.
- R6: If no strobe is low and `adv_n` is high at an edge, `addr_hi`, `beat_addr` and `burst_live` all keep their values.
- R7: When a strobe and `adv_n` are both low at the same edge, the strobe wins. This holds mid-burst too: the sequence restarts from the new start word and no step is taken.
- R8: The fourth advance after a load brings `beat_addr` back to the start word, in both orders.
- R9: While `burst_live` is low, `adv_n` has no effect on `beat_addr`.
- R10: A change on `mode_ilv` takes effect only at the next load. In the middle of a burst it does not change the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe_cpu_n | input | 1 | Processor address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs_n | input | 1 | Chip select, active low |
| cs | input | 1 | Chip select, active high |
| mode_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W+BEAT_W | Start address; low BEAT_W bits are the word in the burst |
| addr_hi | output | ADDR_W | Registered upper address |
| beat_addr | output | BEAT_W | Current burst word address |
| burst_live | output | 1 | High while a selected burst is in progress |

## Verification
The assertions assume that every input is at a known level at each rising edge once the internal reset is released. They also assume that mode and address are read only at load edges, so glitches between edges do not matter. The bench drives all inputs on the falling edge. It parks them at idle (strobes and advance high, chip selected) from time zero and holds reset until the synchronizer has settled. Both strobes are used. Strobe and advance are asserted together in some cycles, and starts of 1 and 3 are used so that the two orders visibly differ.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  localparam int unsigned BEAT_W_DEF = 2;
  localparam int unsigned HI_W_DEF   = 14;
endpackage

// File: rtl/bsq_reset_sync.sv
module bsq_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/bsq_load_ctrl.sv
module bsq_load_ctrl (
  input  logic strobe_cpu_n,
  input  logic strobe_ctl_n,
  input  logic adv_n,
  input  logic cs_n,
  input  logic cs,
  input  logic live_q,
  output logic take,
  output logic load,
  output logic step
);
  logic chip_ok;

  always_comb begin
    take    = !strobe_cpu_n || !strobe_ctl_n;
    chip_ok = !cs_n && cs;
    load    = take && chip_ok;
    // a strobe always masks advance in the same cycle
    step    = !take && !adv_n && live_q;
  end
endmodule

// File: rtl/bsq_beat_counter.sv
module bsq_beat_counter #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] cnt_q
);
  logic [BEAT_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = load || step;
    cnt_d  = load ? '0 : cnt_q + BEAT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map
  import bsq_pkg::*;
#(
  parameter int unsigned BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] cnt,
  input  order_e            order,
  output logic [BEAT_W-1:0] beat
);
  logic [BEAT_W-1:0] lin_w;
  logic [BEAT_W-1:0] xor_w;

  assign lin_w = start + cnt;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
    assign xor_w[b] = start[b] ^ cnt[b];
  end

  always_comb begin
    unique case (order)
      ORD_XOR: beat = xor_w;
      default: beat = lin_w;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W = HI_W_DEF,
  parameter int unsigned BEAT_W = BEAT_W_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     strobe_cpu_n,
  input  logic                     strobe_ctl_n,
  input  logic                     adv_n,
  input  logic                     cs_n,
  input  logic                     cs,
  input  logic                     mode_ilv,
  input  logic [ADDR_W+BEAT_W-1:0] addr_in,
  output logic [ADDR_W-1:0]        addr_hi,
  output logic [BEAT_W-1:0]        beat_addr,
  output logic                     burst_live
);
  localparam int unsigned IN_W = ADDR_W + BEAT_W;

  logic              rst_sync_n;
  logic              take, load, step;
  logic [ADDR_W-1:0] hi_q, hi_d;
  logic [BEAT_W-1:0] start_q, start_d;
  logic [BEAT_W-1:0] cnt_q;
  order_e            mode_q, mode_d;
  logic              live_q, live_d;

  bsq_reset_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  bsq_load_ctrl i_load_ctrl (
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .adv_n        (adv_n),
    .cs_n         (cs_n),
    .cs           (cs),
    .live_q       (live_q),
    .take         (take),
    .load         (load),
    .step         (step)
  );

  bsq_beat_counter #(.BEAT_W(BEAT_W)) i_beat_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (load),
    .step  (step),
    .cnt_q (cnt_q)
  );

  // next state for the captured fields
  always_comb begin
    hi_d    = addr_in[IN_W-1:BEAT_W];
    start_d = addr_in[BEAT_W-1:0];
    mode_d  = order_e'(mode_ilv);
    live_d  = load;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hi_q    <= '0;
      start_q <= '0;
      mode_q  <= ORD_LINEAR;
    end else if (load) begin
      hi_q    <= hi_d;
      start_q <= start_d;
      mode_q  <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      live_q <= 1'b0;
    end else if (take) begin
      live_q <= live_d;
    end
  end

  bsq_order_map #(.BEAT_W(BEAT_W)) i_order_map (
    .start (start_q),
    .cnt   (cnt_q),
    .order (mode_q),
    .beat  (beat_addr)
  );

  assign addr_hi    = hi_q;
  assign burst_live = live_q;
endmodule

// File: rtl/bsq_chk.sv
module bsq_chk #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned BEAT_W = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     strobe_cpu_n,
  input logic                     strobe_ctl_n,
  input logic                     adv_n,
  input logic                     cs_n,
  input logic                     cs,
  input logic [ADDR_W+BEAT_W-1:0] addr_in,
  input logic [ADDR_W-1:0]        addr_hi,
  input logic [BEAT_W-1:0]        beat_addr,
  input logic                     burst_live,
  input logic                     mode_q
);
  logic any_stb, sel_ok;
  assign any_stb = !(strobe_cpu_n && strobe_ctl_n);
  assign sel_ok  = !cs_n && cs;

  // R1
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      reset_zero_chk: assert (addr_hi == '0 && beat_addr == '0 && !burst_live);
    end
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb && sel_ok |=> addr_hi == $past(addr_in[ADDR_W+BEAT_W-1:BEAT_W])
                          && beat_addr == $past(addr_in[BEAT_W-1:0]) && burst_live);

  // R3
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb && !sel_ok |=> !burst_live && $stable(addr_hi) && $stable(beat_addr));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_stb && !adv_n && burst_live && !mode_q
      |=> beat_addr == BEAT_W'($past(beat_addr) + 1'b1));

  // R5
  xor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_stb && !adv_n && burst_live && mode_q
      |=> beat_addr[0] != $past(beat_addr[0]));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_stb && adv_n |=> $stable(beat_addr) && $stable(addr_hi) && $stable(burst_live));

  // R9
  idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_stb && !burst_live |=> $stable(beat_addr) && !burst_live);

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(any_stb && sel_ok) |=> $stable(mode_q));
endmodule

bind burst_addr_seq bsq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_bsq_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .strobe_cpu_n (strobe_cpu_n),
  .strobe_ctl_n (strobe_ctl_n),
  .adv_n        (adv_n),
  .cs_n         (cs_n),
  .cs           (cs),
  .addr_in      (addr_in),
  .addr_hi      (addr_hi),
  .beat_addr    (beat_addr),
  .burst_live   (burst_live),
  .mode_q       (mode_q)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  localparam int unsigned HW = 14;
  localparam int unsigned BW = 2;

  logic          clk;
  logic          rst_n;
  logic          strobe_cpu_n, strobe_ctl_n, adv_n, cs_n, cs, mode_ilv;
  logic [HW+BW-1:0] addr_in;
  logic [HW-1:0] addr_hi;
  logic [BW-1:0] beat_addr;
  logic          burst_live;

  burst_addr_seq #(.ADDR_W(HW), .BEAT_W(BW)) i_burst_addr_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .adv_n        (adv_n),
    .cs_n         (cs_n),
    .cs           (cs),
    .mode_ilv     (mode_ilv),
    .addr_in      (addr_in),
    .addr_hi      (addr_hi),
    .beat_addr    (beat_addr),
    .burst_live   (burst_live)
  );

  typedef struct packed {
    logic [HW-1:0] hi;
    logic [BW-1:0] beat;
    logic          live;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  // reference state, kept from the requirements
  logic [HW-1:0] m_hi    = '0;
  logic [BW-1:0] m_start = '0;
  logic [BW-1:0] m_cnt   = '0;
  logic          m_mode  = 1'b0;
  logic          m_live  = 1'b0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic compare(input exp_t e, input string tag);
    checks++;
    if (addr_hi !== e.hi || beat_addr !== e.beat || burst_live !== e.live) begin
      fails++;
      $display("FAIL %s: got hi=%h beat=%0d live=%b, expected hi=%h beat=%0d live=%b",
               tag, addr_hi, beat_addr, burst_live, e.hi, e.beat, e.live);
    end
  endtask

  task automatic step(input bit cpu_n, input bit ctl_n, input bit a_n,
                      input bit c_n, input bit c_h, input bit md,
                      input logic [HW-1:0] hi, input logic [BW-1:0] lo,
                      input string tag);
    exp_t e;
    bit   tk, ok;
    @(negedge clk);
    strobe_cpu_n = cpu_n; strobe_ctl_n = ctl_n; adv_n = a_n;
    cs_n = c_n; cs = c_h; mode_ilv = md; addr_in = {hi, lo};
    tk = !cpu_n || !ctl_n;
    ok = !c_n && c_h;
    if (tk) begin
      if (ok) begin
        m_hi = hi; m_start = lo; m_mode = md; m_cnt = '0;
      end
      m_live = ok;
    end else if (!a_n && m_live) begin
      m_cnt = m_cnt + 1'b1;
    end
    e.hi   = m_hi;
    e.beat = m_mode ? (m_start ^ m_cnt) : BW'(m_start + m_cnt);
    e.live = m_live;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: one expected item per edge after it was queued
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    exp_t z;
    rst_n = 1'b0;
    strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
    cs_n = 1'b0; cs = 1'b1; mode_ilv = 1'b0; addr_in = '0;
    repeat (3) @(posedge clk);
    #3;
    z = '0;
    compare(z, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    compare(z, "R1 after release");

    step(0,1,1,0,1,0,14'h1234,2'd1,"R2 load by processor strobe");
    step(1,1,0,0,1,0,14'h0,2'd0,"R4 linear beat 2");
    step(1,1,0,0,1,0,14'h0,2'd0,"R4 linear beat 3");
    step(1,1,0,0,1,0,14'h0,2'd0,"R4 linear beat 4 wraps");
    step(1,1,0,0,1,0,14'h0,2'd0,"R8 linear back to start");
    step(1,1,1,0,1,0,14'h0,2'd0,"R6 hold");
    step(1,1,0,0,1,1,14'h0,2'd0,"R10 mode change mid burst");
    step(1,0,1,0,1,1,14'h0abc,2'd1,"R2 load by controller strobe");
    step(1,1,0,0,1,1,14'h0,2'd0,"R5 interleaved beat 2");
    step(1,1,0,0,1,0,14'h0,2'd0,"R5 interleaved beat 3");
    step(1,1,0,0,1,0,14'h0,2'd0,"R5 interleaved beat 4");
    step(1,1,0,0,1,0,14'h0,2'd0,"R8 interleaved back to start");
    step(0,1,0,0,1,1,14'h2222,2'd3,"R7 strobe beats advance");
    step(1,1,0,0,1,0,14'h0,2'd0,"R5 interleaved from 3");
    step(1,0,0,0,1,0,14'h3fff,2'd2,"R7 restart mid burst");
    step(1,1,0,0,1,1,14'h0,2'd0,"R4 linear from 2");
    step(0,1,1,1,1,0,14'h1111,2'd0,"R3 strobe with cs_n high");
    step(1,1,0,0,1,0,14'h0,2'd0,"R9 advance while idle");
    step(1,0,0,0,0,1,14'h2aaa,2'd1,"R3 strobe with cs low");
    step(1,1,0,0,1,0,14'h0,2'd0,"R9 advance still idle");
    step(1,0,1,0,1,1,14'h0001,2'd0,"R2 reload after deselect");
    step(1,1,0,0,1,0,14'h0,2'd0,"R5 interleaved from 0");
    @(negedge clk);
    strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
    repeat (3) @(posedge clk);
    #6;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no end, expected end within 5000 cycles");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule